// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is a cycle-based model of the command interface of a byte-wide NOR flash. The host issues single-cycle bus writes, each with an address and a data byte. The block decodes unlock prefixes and command codes from these writes. On single-cycle reads it returns stored array bytes, identification codes or program status. The memory cells are a small internal byte array. After reset every cell holds the erased value FFh.

Two unlock writes come first: AAh to address 555h, then 55h to address 2AAh. A command write to 555h follows them. Command 90h enters identification mode. Command A0h arms a byte program, and the next write gives the target address and data. While a program is running, the ready output is low, status reads give a polling bit and a toggle bit, and every write is ignored. A per-sector protection register is loaded at reset. A program aimed at a protected sector is dropped.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the block is in array-read mode with ready high and rdata 00h. A read of any cell returns FFh.
- R2: A write that does not match the next expected step returns the decoder to array-read mode. The steps are AAh@555h, then 55h@2AAh, then a command at 555h. After a mismatch, a later command write has no effect.
- R3: Two unlock writes followed by 90h@555h enter identification mode. The block stays in that mode through any number of reads and through any write whose data is not F0h.
- R4: In identification mode, the read address bits [5:0] select the returned value: 00h gives 37h, 01h gives 92h, 03h gives 7Fh, and 02h gives 01h if the addressed sector is protected or 00h if it is not. Every other offset returns 00h.
- R5: A byte program takes four writes: two unlock writes, A0h@555h, then the target address and data. Ready is low for exactly 8 cycles (BUSY_CYCLES), starting in the cycle after the target write. Targets may be at any address, in any order, across sector boundaries.
- R6: While ready is low, every write is ignored, the reset command F0h included. Afterwards the block returns to array-read mode by itself.
- R7: A read while ready is low returns status. Bit 7 is the complement of bit 7 of the target data, bit 6 alternates on successive status reads, and bits 5:0 are 0.
- R8: A program stores the old byte ANDed with the new data. A bit that is 0 stays 0.
- R9: Sectors are 64 bytes, selected by address bits [8:6]. With the default mask, sector 2 (080h to 0BFh) is protected. A program write to a protected sector is dropped: the cell is unchanged and ready never goes low.
- R10: A write with data F0h at any address aborts an unfinished unlock sequence and leaves identification mode. Either way it returns to array-read mode.
- R11: rdata is registered. It updates at the clock edge where rd_en is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Single-cycle bus write strobe |
| rd_en | input | 1 | Single-cycle bus read strobe |
| addr | input | 11 | Bus address; bits [8:0] index the array |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Registered read data: array byte, ID code or status |
| ready | output | 1 | High when no program operation is running |

## Verification
A decoder left in a wrong state shows up on the first read after the faulty write. If the decoder stays in an unlock step, later writes can program a cell that should not change. If it is stuck in identification mode, array reads return ID codes. A wrong busy count shifts the edge at which ready rises by at least one cycle. A program merge that sets bits, or that ignores protection, is seen in the next read of the target cell. Every check therefore samples a read one cycle after rd_en, or samples ready on the cycle it is due to change.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMD_AW = 11;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_AUTO,
    ST_PSET,
    ST_BUSY
  } seq_state_e;

  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0]        KEY_DATA_A = 8'hAA;
  localparam logic [7:0]        KEY_DATA_B = 8'h55;
  localparam logic [7:0]        OP_IDENT   = 8'h90;
  localparam logic [7:0]        OP_PROG    = 8'hA0;
  localparam logic [7:0]        OP_RESET   = 8'hF0;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  parameter int CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              sect_prot,
  output seq_state_e        state_o,
  output logic              pgm_fire
);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign pgm_fire = wr_en && (st_q == ST_PSET) && !sect_prot;
  assign state_o  = st_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_READ: begin
        if (wr_en && addr == KEY_ADDR_A && wdata == KEY_DATA_A) st_d = ST_UNL1;
      end
      ST_UNL1: begin
        if (wr_en) st_d = (addr == KEY_ADDR_B && wdata == KEY_DATA_B) ? ST_UNL2 : ST_READ;
      end
      ST_UNL2: begin
        if (wr_en) begin
          if (addr == KEY_ADDR_A && wdata == OP_IDENT)     st_d = ST_AUTO;
          else if (addr == KEY_ADDR_A && wdata == OP_PROG) st_d = ST_PSET;
          else                                             st_d = ST_READ;
        end
      end
      ST_AUTO: begin
        if (wr_en && wdata == OP_RESET) st_d = ST_READ;
      end
      ST_PSET: begin
        if (wr_en) begin
          if (sect_prot) begin
            st_d = ST_READ;
          end else begin
            st_d  = ST_BUSY;
            cnt_d = CNT_W'(BUSY_CYCLES - 1);
          end
        end
      end
      ST_BUSY: begin
        if (cnt_q == '0) st_d = ST_READ;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_READ;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Second unlock step is only ever entered from the first one (R2)
  assert_unlock_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UNL2 && $past(st_q) != ST_UNL2) |-> ($past(st_q) == ST_UNL1));

  assert_ident_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AUTO && !(wr_en && wdata == OP_RESET)) |=> (st_q == ST_AUTO));

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && cnt_q != '0) |=> (st_q == ST_BUSY));

  assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && cnt_q == '0) |=> (st_q == ST_READ));

  assert_prot_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PSET && wr_en && sect_prot) |=> (st_q == ST_READ));

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_en,
  input  logic [AW-1:0] pgm_addr,
  input  logic [7:0]    pgm_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (pgm_en) begin
      mem_q[pgm_addr] <= mem_q[pgm_addr] & pgm_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // checker copies of the last program access
  logic          chk_vld;
  logic [AW-1:0] chk_addr;
  logic [7:0]    chk_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld  <= 1'b0;
      chk_addr <= '0;
      chk_old  <= 8'h00;
    end else begin
      chk_vld <= pgm_en;
      if (pgm_en) begin
        chk_addr <= pgm_addr;
        chk_old  <= mem_q[pgm_addr];
      end
    end
  end

  // a program never raises a bit that was 0 (R8)
  assert_no_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> ((mem_q[chk_addr] & ~chk_old) == 8'h00));

endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int         OFS_W     = 6,
  parameter logic [7:0] MFR_CODE  = 8'h37,
  parameter logic [7:0] DEV_CODE  = 8'h92,
  parameter logic [7:0] CONT_CODE = 8'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  seq_state_e       state,
  input  logic [OFS_W-1:0] offset,
  input  logic             sect_prot,
  input  logic [7:0]       arr_data,
  input  logic             pgm_fire,
  input  logic             pgm_msb,
  output logic [7:0]       rdata
);

  logic       tgt7_q, tog_q;
  logic [7:0] rd_q, rd_d, id_val;
  logic       busy;

  assign busy = (state == ST_BUSY);

  always_comb begin
    unique case (offset)
      OFS_W'(0): id_val = MFR_CODE;
      OFS_W'(1): id_val = DEV_CODE;
      OFS_W'(2): id_val = {7'b0, sect_prot};
      OFS_W'(3): id_val = CONT_CODE;
      default:   id_val = 8'h00;
    endcase
  end

  always_comb begin
    if (busy)                  rd_d = {~tgt7_q, tog_q, 6'b0};
    else if (state == ST_AUTO) rd_d = id_val;
    else                       rd_d = arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 8'h00;
      tgt7_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (rd_en)         rd_q   <= rd_d;
      if (pgm_fire)      tgt7_q <= pgm_msb;
      if (rd_en && busy) tog_q  <= ~tog_q;
    end
  end

  assign rdata = rd_q;

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) ##1 (rd_en && busy) |=> (rdata[6] != $past(rdata[6])));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         MEM_DEPTH   = 512,
  parameter int         SECT_BYTES  = 64,
  parameter int         BUSY_CYCLES = 8,
  parameter logic [7:0] MFR_CODE    = 8'h37,
  parameter logic [7:0] DEV_CODE    = 8'h92,
  parameter logic [7:0] CONT_CODE   = 8'h7F,
  parameter logic [7:0] PROT_MASK   = 8'b0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CMD_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ready
);

  localparam int MEM_AW  = $clog2(MEM_DEPTH);
  localparam int SECT_AW = $clog2(SECT_BYTES);
  localparam int N_SECT  = MEM_DEPTH / SECT_BYTES;
  localparam int CNT_W   = $clog2(BUSY_CYCLES + 1);

  logic              rst_meta, rst_sync;
  logic [N_SECT-1:0] prot_q;
  logic              sect_prot, pgm_fire;
  logic [7:0]        arr_data;
  seq_state_e        state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) prot_q <= PROT_MASK[N_SECT-1:0];
    else           prot_q <= prot_q;
  end

  assign sect_prot = prot_q[addr[MEM_AW-1:SECT_AW]];
  assign ready     = (state != ST_BUSY);

  flash_seq_fsm #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .sect_prot(sect_prot),
    .state_o  (state),
    .pgm_fire (pgm_fire)
  );

  flash_cell_array #(
    .DEPTH(MEM_DEPTH),
    .AW   (MEM_AW)
  ) u_cells (
    .clk     (clk),
    .rst_n   (rst_sync),
    .pgm_en  (pgm_fire),
    .pgm_addr(addr[MEM_AW-1:0]),
    .pgm_data(wdata),
    .rd_addr (addr[MEM_AW-1:0]),
    .rd_data (arr_data)
  );

  flash_rd_mux #(
    .OFS_W    (SECT_AW),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE),
    .CONT_CODE(CONT_CODE)
  ) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_sync),
    .rd_en    (rd_en),
    .state    (state),
    .offset   (addr[SECT_AW-1:0]),
    .sect_prot(sect_prot),
    .arr_data (arr_data),
    .pgm_fire (pgm_fire),
    .pgm_msb  (wdata[7]),
    .rdata    (rdata)
  );

  // a write to a protected sector never starts a busy period (R9)
  assert_prot_ready_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    (state == ST_PSET && wr_en && sect_prot) |=> ready);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam int         BUSY = 8;
  localparam logic [7:0] MFR  = 8'h37;
  localparam logic [7:0] DEV  = 8'h92;
  localparam logic [7:0] CONT = 8'h7F;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [10:0] addr;
  logic [7:0]  wdata, rdata;
  logic        ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata),
    .ready(ready)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [10:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic unlock();
    do_write(11'h555, 8'hAA);
    do_write(11'h2AA, 8'h55);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic program_byte(input logic [10:0] a, input logic [7:0] d);
    int n;
    unlock();
    do_write(11'h555, 8'hA0);
    do_write(a, d);
    wait_ready(n);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ready after reset", {7'b0, ready}, 8'h01);
    check("R1 rdata after reset", rdata, 8'h00);
    do_read(11'h1FF, v);
    check("R1 erased cell", v, 8'hFF);
    addr = 11'h000;
    repeat (2) @(negedge clk);
    check("R11 rdata held without rd_en", rdata, 8'hFF);
  endtask

  task automatic t_program_busy();
    logic [7:0] s1, s2, v;
    int n;
    unlock();
    do_write(11'h555, 8'hA0);
    do_write(11'h045, 8'h5A);
    check("R5 ready low after target write", {7'b0, ready}, 8'h00);
    do_read(11'h045, s1);
    do_read(11'h100, s2);
    check("R7 poll bit7 and low bits", s1 & 8'hBF, 8'h80);
    check("R7 toggle bit6 alternates", {7'b0, s1[6] ^ s2[6]}, 8'h01);
    do_write(11'h000, 8'hF0);
    do_write(11'h555, 8'hAA);
    check("R6 reset command ignored while busy", {7'b0, ready}, 8'h00);
    wait_ready(n);
    check("R5 busy length", 8'(4 + n), 8'(BUSY));
    do_read(11'h045, v);
    check("R5 programmed value", v, 8'h5A);
    do_write(11'h2AA, 8'h55);
    do_write(11'h555, 8'h90);
    do_read(11'h000, v);
    check("R6 write during busy left no unlock", v, 8'hFF);
  endtask

  task automatic t_and_merge();
    logic [7:0] v;
    program_byte(11'h010, 8'hF0);
    do_read(11'h010, v);
    check("R8 first program", v, 8'hF0);
    program_byte(11'h010, 8'h3C);
    do_read(11'h010, v);
    check("R8 AND merge", v, 8'h30);
    program_byte(11'h010, 8'hFF);
    do_read(11'h010, v);
    check("R8 zero bits stay zero", v, 8'h30);
  endtask

  task automatic t_cross_sector();
    logic [7:0] v;
    program_byte(11'h1FF, 8'h01);
    program_byte(11'h040, 8'h22);
    program_byte(11'h03F, 8'h11);
    do_read(11'h03F, v);
    check("R5 last byte of sector 0", v, 8'h11);
    do_read(11'h040, v);
    check("R5 first byte of sector 1", v, 8'h22);
    do_read(11'h1FF, v);
    check("R5 top cell", v, 8'h01);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    unlock();
    do_write(11'h555, 8'hA0);
    do_write(11'h090, 8'h00);
    check("R9 no busy on protected sector", {7'b0, ready}, 8'h01);
    do_read(11'h090, v);
    check("R9 protected cell unchanged", v, 8'hFF);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    unlock();
    do_write(11'h555, 8'h90);
    do_read(11'h000, v); check("R4 manufacturer code", v, MFR);
    do_read(11'h001, v); check("R4 device code", v, DEV);
    do_read(11'h003, v); check("R4 continuation code", v, CONT);
    do_read(11'h082, v); check("R4 protected sector", v, 8'h01);
    do_read(11'h042, v); check("R4 unprotected sector", v, 8'h00);
    do_read(11'h005, v); check("R4 other offset", v, 8'h00);
    do_write(11'h555, 8'hAA);
    do_read(11'h000, v); check("R3 mode kept after non-reset write", v, MFR);
    do_read(11'h000, v); check("R3 mode kept on repeated read", v, MFR);
    do_write(11'h3AB, 8'hF0);
    do_read(11'h000, v); check("R10 reset leaves ident mode", v, 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    unlock();
    do_write(11'h7FF, 8'hF0);
    do_write(11'h555, 8'hA0);
    do_write(11'h020, 8'h00);
    check("R10 aborted sequence no busy", {7'b0, ready}, 8'h01);
    do_read(11'h020, v);
    check("R10 aborted sequence no program", v, 8'hFF);
  endtask

  task automatic t_mismatch();
    logic [7:0] v;
    do_write(11'h555, 8'hAA);
    do_write(11'h2AA, 8'h56);
    do_write(11'h555, 8'hA0);
    do_write(11'h030, 8'h00);
    do_read(11'h030, v);
    check("R2 wrong unlock data", v, 8'hFF);
    do_write(11'h555, 8'hAA);
    do_write(11'h2AB, 8'h55);
    do_write(11'h555, 8'h90);
    do_read(11'h000, v);
    check("R2 wrong unlock address", v, 8'hFF);
    unlock();
    do_write(11'h554, 8'h90);
    do_read(11'h000, v);
    check("R2 wrong command address", v, 8'hFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_program_busy();
    t_and_merge();
    t_cross_sector();
    t_protect();
    t_ident();
    t_abort();
    t_mismatch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule